// File: doc/BRIEF.md
# Prefixed Opcode Fetch Front End

This block is the first stage of a byte-serial instruction pipeline. It holds an instruction pointer and reads the instruction stream one byte at a time through a valid/ready byte port. It walks the opcode bytes of each instruction and stops when it has a complete opcode. It then presents one record downstream: the address of the first byte, up to three opcode bytes and a class tag. Operand bytes, ModR/M decoding and execution belong to later stages.

There are three escape bytes. A first byte of 0x0F starts a two-byte opcode. A first byte of 0xF2 or 0xF3 starts a prefixed form, which can end at the second byte or go through 0x0F to a third byte. Byte 0xF4 is halt: it moves the pointer to a configured end-of-program address. Every other opcode byte is checked against a per-class table of supported codes held on input ports.

An unsupported byte stops the front end and reports an error code that names the level where decoding failed. A halt also stops the front end. Fetching resumes only on a restart pulse or a reset.

The state machine has six states:
- FETCH_OP0 reads the first byte.
- FETCH_OP1_0F reads the byte after 0x0F.
- FETCH_OP1_PFX reads the byte after 0xF2 or 0xF3.
- FETCH_OP2 reads the third byte.
- EMIT presents the record.
- STOP is idle.

Its transitions are:
- From FETCH_OP0: 0x0F goes to FETCH_OP1_0F. 0xF2 or 0xF3 goes to FETCH_OP1_PFX. 0xF4 or a supported byte goes to EMIT. An unsupported byte goes to STOP.
- From FETCH_OP1_PFX: 0x0F goes to FETCH_OP2. A supported byte goes to EMIT. An unsupported byte goes to STOP.
- From FETCH_OP1_0F and FETCH_OP2: a supported byte goes to EMIT. An unsupported byte goes to STOP.
- From EMIT, once the record is accepted: a halt record goes to STOP, any other record goes to FETCH_OP0.
- From STOP: a restart pulse goes to FETCH_OP0.

Top module: `opfetch_front`

## Requirements
- R1: After reset the pointer is 1. The first request addresses byte 1, no record is valid, `stopped` is 0 and `err_code` is 0.
- R2: A request holds its address until `fetch_ready`. Each accepted byte other than a halt byte moves the pointer up by exactly one.
- R3: A first byte of 0xF4 produces a record with class 6 and op0=0xF4. Accepting that byte loads the pointer with `end_addr`. Once the record is accepted the block stops with `err_code` 0, and a restart fetches from `end_addr`.
- R4: After a first byte of 0x0F, a second byte b with `tbl_esc[b]`=1 produces class 1, op0=0x0F, op1=b.
- R5: After a first byte of 0xF2 (or 0xF3), a second byte b other than 0x0F with `tbl_pf2[b]` (or `tbl_pf3[b]`) set produces class 2 (or 3), op0=prefix, op1=b.
- R6: After 0xF2 0x0F (or 0xF3 0x0F), a third byte b with `tbl_pf2_esc[b]` (or `tbl_pf3_esc[b]`) set produces class 4 (or 5), op0=prefix, op1=0x0F, op2=b.
- R7: Any other first byte b with `tbl_one[b]`=1 produces class 0, op0=b, op1=op2=0. Opcode bytes that are not used are 0 in every record.
- R8: An unsupported byte produces no record and stops the block. `err_code` names the level: 1 for the first byte, 2 for the byte after 0x0F, 3 for the byte after a prefix, 4 for the third byte.
- R9: Each record's `out_addr` is the address of its first opcode byte.
- R10: While stopped no bytes are requested. A restart pulse clears `err_code` and resumes fetching at the byte after the last one accepted.
- R11: A valid record keeps all of its fields stable until `out_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| end_addr | input | AW | Pointer value loaded by halt |
| restart | input | 1 | Resume pulse, used only while stopped |
| tbl_one | input | 256 | Supported one-byte opcodes |
| tbl_esc | input | 256 | Supported second bytes after 0x0F |
| tbl_pf2 | input | 256 | Supported second bytes after 0xF2 |
| tbl_pf3 | input | 256 | Supported second bytes after 0xF3 |
| tbl_pf2_esc | input | 256 | Supported third bytes after 0xF2 0x0F |
| tbl_pf3_esc | input | 256 | Supported third bytes after 0xF3 0x0F |
| fetch_valid | output | 1 | Byte request |
| fetch_addr | output | AW | Requested byte address |
| fetch_ready | input | 1 | Memory accepts the request and returns the byte |
| fetch_data | input | 8 | Returned byte, valid with fetch_ready |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Downstream accepts the record |
| out_addr | output | AW | Address of the first opcode byte |
| out_op0 | output | 8 | First opcode byte |
| out_op1 | output | 8 | Second opcode byte or 0 |
| out_op2 | output | 8 | Third opcode byte or 0 |
| out_class | output | 3 | Class tag, 0 to 6 |
| stopped | output | 1 | Block is idle after a halt or an error |
| err_code | output | 3 | 0 when there is no error, otherwise the failing level 1 to 4 |

## Verification
The pointer's only window to the outside is `fetch_addr`. A miscounted pointer therefore shows up on the very next byte request, and in the start address of the next record. A state register that takes a wrong branch shows up within the same instruction: the class tag, the opcode bytes or the error level is wrong by the time the record or the stop appears. Each sweep feeds every byte value at one decode level against a table pattern the bench computes arithmetically. Any mismatch between the level the machine is in and the table it consults therefore turns into a wrong record or a wrong error within a few cycles.

// File: rtl/opfetch_pkg.sv
package opfetch_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_CODES = 1 << BYTE_W;

    localparam logic [BYTE_W-1:0] B_ESC  = 8'h0F;
    localparam logic [BYTE_W-1:0] B_PF2  = 8'hF2;
    localparam logic [BYTE_W-1:0] B_PF3  = 8'hF3;
    localparam logic [BYTE_W-1:0] B_HALT = 8'hF4;

    typedef enum logic [2:0] {
        CL_ONE    = 3'd0,
        CL_ESC    = 3'd1,
        CL_PF2    = 3'd2,
        CL_PF3    = 3'd3,
        CL_PF2ESC = 3'd4,
        CL_PF3ESC = 3'd5,
        CL_HALT   = 3'd6
    } op_class_e;

    typedef enum logic [2:0] {
        ER_NONE  = 3'd0,
        ER_FIRST = 3'd1,
        ER_ESC   = 3'd2,
        ER_PFX   = 3'd3,
        ER_THIRD = 3'd4
    } err_e;

    typedef enum logic [1:0] {
        LV_FIRST,
        LV_ESC,
        LV_PFX,
        LV_THIRD
    } level_e;

    typedef enum logic [2:0] {
        FETCH_OP0,
        FETCH_OP1_0F,
        FETCH_OP1_PFX,
        FETCH_OP2,
        EMIT,
        STOP
    } state_e;
endpackage

// File: rtl/opfetch_ptr.sv
module opfetch_ptr #(
    parameter int          AW        = 32,
    parameter logic [AW-1:0] RESET_VAL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] ip
);
    always_ff @(posedge clk) begin
        if (!rst_n)    ip <= RESET_VAL;
        else if (load) ip <= load_val;
        else if (inc)  ip <= ip + 1'b1;
    end

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !load |=> ip == $past(ip) + 1'b1);

    // R3
    halt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ip == $past(load_val));

    // R2
    excl_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && load));
endmodule

// File: rtl/opfetch_lookup.sv
module opfetch_lookup
    import opfetch_pkg::*;
(
    input  level_e               level,
    input  logic                 alt,
    input  logic [BYTE_W-1:0]    code,
    input  logic [NUM_CODES-1:0] tbl_one,
    input  logic [NUM_CODES-1:0] tbl_esc,
    input  logic [NUM_CODES-1:0] tbl_pf2,
    input  logic [NUM_CODES-1:0] tbl_pf3,
    input  logic [NUM_CODES-1:0] tbl_pf2_esc,
    input  logic [NUM_CODES-1:0] tbl_pf3_esc,
    output logic                 hit
);
    always_comb begin
        hit = 1'b0;
        unique case (level)
            LV_FIRST: hit = tbl_one[code];
            LV_ESC:   hit = tbl_esc[code];
            LV_PFX:   hit = alt ? tbl_pf3[code] : tbl_pf2[code];
            LV_THIRD: hit = alt ? tbl_pf3_esc[code] : tbl_pf2_esc[code];
        endcase
    end
endmodule

// File: rtl/opfetch_fsm.sv
module opfetch_fsm
    import opfetch_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    input  logic [BYTE_W-1:0] fetch_data,
    input  logic [AW-1:0]     ip,
    input  logic              hit,
    output level_e            level,
    output logic              alt,
    output logic              ptr_inc,
    output logic              ptr_load,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [AW-1:0]     out_addr,
    output logic [BYTE_W-1:0] out_op0,
    output logic [BYTE_W-1:0] out_op1,
    output logic [BYTE_W-1:0] out_op2,
    output op_class_e         out_class,
    output logic              stopped,
    output err_e              err_code
);
    state_e            state_q, state_d;
    op_class_e         cls_q, cls_d;
    err_e              err_q, err_d;
    logic [AW-1:0]     addr_q;
    logic [BYTE_W-1:0] op0_q, op1_q, op2_q;
    logic              take;

    assign take     = fetch_valid && fetch_ready;
    assign ptr_load = take && (state_q == FETCH_OP0) && (fetch_data == B_HALT);
    assign ptr_inc  = take && !ptr_load;
    assign alt      = (op0_q == B_PF3);

    // next state and per-state outputs
    always_comb begin
        state_d     = state_q;
        cls_d       = cls_q;
        err_d       = err_q;
        fetch_valid = 1'b0;
        out_valid   = 1'b0;
        level       = LV_FIRST;
        unique case (state_q)
            FETCH_OP0: begin
                fetch_valid = 1'b1;
                level       = LV_FIRST;
                if (fetch_ready) begin
                    if (fetch_data == B_ESC) begin
                        state_d = FETCH_OP1_0F;
                    end else if (fetch_data == B_PF2 || fetch_data == B_PF3) begin
                        state_d = FETCH_OP1_PFX;
                    end else if (fetch_data == B_HALT) begin
                        cls_d   = CL_HALT;
                        state_d = EMIT;
                    end else if (hit) begin
                        cls_d   = CL_ONE;
                        state_d = EMIT;
                    end else begin
                        err_d   = ER_FIRST;
                        state_d = STOP;
                    end
                end
            end
            FETCH_OP1_0F: begin
                fetch_valid = 1'b1;
                level       = LV_ESC;
                if (fetch_ready) begin
                    if (hit) begin
                        cls_d   = CL_ESC;
                        state_d = EMIT;
                    end else begin
                        err_d   = ER_ESC;
                        state_d = STOP;
                    end
                end
            end
            FETCH_OP1_PFX: begin
                fetch_valid = 1'b1;
                level       = LV_PFX;
                if (fetch_ready) begin
                    if (fetch_data == B_ESC) begin
                        state_d = FETCH_OP2;
                    end else if (hit) begin
                        cls_d   = alt ? CL_PF3 : CL_PF2;
                        state_d = EMIT;
                    end else begin
                        err_d   = ER_PFX;
                        state_d = STOP;
                    end
                end
            end
            FETCH_OP2: begin
                fetch_valid = 1'b1;
                level       = LV_THIRD;
                if (fetch_ready) begin
                    if (hit) begin
                        cls_d   = alt ? CL_PF3ESC : CL_PF2ESC;
                        state_d = EMIT;
                    end else begin
                        err_d   = ER_THIRD;
                        state_d = STOP;
                    end
                end
            end
            EMIT: begin
                out_valid = 1'b1;
                if (out_ready) state_d = (cls_q == CL_HALT) ? STOP : FETCH_OP0;
            end
            STOP: begin
                if (restart) begin
                    err_d   = ER_NONE;
                    state_d = FETCH_OP0;
                end
            end
            default: state_d = FETCH_OP0;
        endcase
    end

    // state register and record capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FETCH_OP0;
            cls_q   <= CL_ONE;
            err_q   <= ER_NONE;
            addr_q  <= '0;
            op0_q   <= '0;
            op1_q   <= '0;
            op2_q   <= '0;
        end else begin
            state_q <= state_d;
            cls_q   <= cls_d;
            err_q   <= err_d;
            if (take) begin
                case (state_q)
                    FETCH_OP0: begin
                        addr_q <= ip;
                        op0_q  <= fetch_data;
                        op1_q  <= '0;
                        op2_q  <= '0;
                    end
                    FETCH_OP1_0F, FETCH_OP1_PFX: op1_q <= fetch_data;
                    FETCH_OP2:                   op2_q <= fetch_data;
                    default: ;
                endcase
            end
        end
    end

    assign out_addr  = addr_q;
    assign out_op0   = op0_q;
    assign out_op1   = op1_q;
    assign out_op2   = op2_q;
    assign out_class = cls_q;
    assign stopped   = (state_q == STOP);
    assign err_code  = err_q;

    // R11
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_op0)
            && $stable(out_op1) && $stable(out_op2) && $stable(out_class));

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_code != ER_NONE |-> stopped && !out_valid);

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && !restart |=> !fetch_valid);

    // R3
    halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_class == CL_HALT |=> stopped && err_code == ER_NONE);
endmodule

// File: rtl/opfetch_front.sv
module opfetch_front
    import opfetch_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        end_addr,
    input  logic                 restart,
    input  logic [NUM_CODES-1:0] tbl_one,
    input  logic [NUM_CODES-1:0] tbl_esc,
    input  logic [NUM_CODES-1:0] tbl_pf2,
    input  logic [NUM_CODES-1:0] tbl_pf3,
    input  logic [NUM_CODES-1:0] tbl_pf2_esc,
    input  logic [NUM_CODES-1:0] tbl_pf3_esc,
    output logic                 fetch_valid,
    output logic [AW-1:0]        fetch_addr,
    input  logic                 fetch_ready,
    input  logic [BYTE_W-1:0]    fetch_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [AW-1:0]        out_addr,
    output logic [BYTE_W-1:0]    out_op0,
    output logic [BYTE_W-1:0]    out_op1,
    output logic [BYTE_W-1:0]    out_op2,
    output logic [2:0]           out_class,
    output logic                 stopped,
    output logic [2:0]           err_code
);
    localparam logic [AW-1:0] IP_AFTER_RESET = AW'(1);

    logic      ptr_inc, ptr_load, hit, alt;
    logic [AW-1:0] ip;
    level_e    level;
    op_class_e cls;
    err_e      err;

    opfetch_ptr #(.AW(AW), .RESET_VAL(IP_AFTER_RESET)) u_ptr (
        .clk(clk), .rst_n(rst_n), .inc(ptr_inc), .load(ptr_load),
        .load_val(end_addr), .ip(ip)
    );

    opfetch_lookup u_lookup (
        .level(level), .alt(alt), .code(fetch_data),
        .tbl_one(tbl_one), .tbl_esc(tbl_esc), .tbl_pf2(tbl_pf2), .tbl_pf3(tbl_pf3),
        .tbl_pf2_esc(tbl_pf2_esc), .tbl_pf3_esc(tbl_pf3_esc), .hit(hit)
    );

    opfetch_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .ip(ip), .hit(hit), .level(level), .alt(alt),
        .ptr_inc(ptr_inc), .ptr_load(ptr_load),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_op0(out_op0), .out_op1(out_op1), .out_op2(out_op2), .out_class(cls),
        .stopped(stopped), .err_code(err)
    );

    assign fetch_addr = ip;
    assign out_class  = cls;
    assign err_code   = err;
endmodule

// File: tb/opfetch_front_bench.sv
module opfetch_front_bench;
    localparam int AW = 32;
    localparam logic [31:0] END_VAL = 32'h0000_0300;

    logic          clk = 1'b0;
    logic          rst_n, restart, fetch_ready, out_ready;
    logic [AW-1:0] end_addr;
    logic [255:0]  tbl_one, tbl_esc, tbl_pf2, tbl_pf3, tbl_pf2_esc, tbl_pf3_esc;
    logic          fetch_valid, out_valid, stopped;
    logic [AW-1:0] fetch_addr, out_addr;
    logic [7:0]    fetch_data, out_op0, out_op1, out_op2;
    logic [2:0]    out_class, err_code;

    logic [7:0]    mem [0:2047];
    logic [31:0]   pc_w;
    int            total = 0;
    int            bad = 0;
    int            rc = 0;

    always #10 clk = ~clk;

    assign fetch_data = mem[fetch_addr[10:0]];

    opfetch_front #(.AW(AW)) u_opfetch_front (
        .clk(clk), .rst_n(rst_n), .end_addr(end_addr), .restart(restart),
        .tbl_one(tbl_one), .tbl_esc(tbl_esc), .tbl_pf2(tbl_pf2), .tbl_pf3(tbl_pf3),
        .tbl_pf2_esc(tbl_pf2_esc), .tbl_pf3_esc(tbl_pf3_esc),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .fetch_data(fetch_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_op0(out_op0), .out_op1(out_op1), .out_op2(out_op2),
        .out_class(out_class), .stopped(stopped), .err_code(err_code)
    );

    function automatic bit ok_one(int b);     return (b % 3) != 0;     endfunction
    function automatic bit ok_esc(int b);     return b[0];             endfunction
    function automatic bit ok_pf2(int b);     return (b % 5) != 1;     endfunction
    function automatic bit ok_pf3(int b);     return b[1];             endfunction
    function automatic bit ok_pf2_esc(int b); return (b % 7) < 4;      endfunction
    function automatic bit ok_pf3_esc(int b); return b[2] ^ b[5];      endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        mem[pc_w[10:0]] = b;
        pc_w = pc_w + 1;
    endtask

    task automatic wait_evt();
        while (!(out_valid || stopped)) @(negedge clk);
    endtask

    task automatic expect_rec(input logic [31:0] a, input logic [7:0] o0, input logic [7:0] o1,
                              input logic [7:0] o2, input logic [2:0] c, input string req);
        logic [58:0] exp, act;
        exp = {a, o0, o1, o2, c};
        wait_evt();
        act = {out_addr, out_op0, out_op1, out_op2, out_class};
        chk(out_valid && act == exp, req, {4'd0, out_valid, act}, {4'd0, 1'b1, exp});
        @(negedge clk);
        act = {out_addr, out_op0, out_op1, out_op2, out_class};
        chk(out_valid && act == exp, "R11 hold", {4'd0, out_valid, act}, {4'd0, 1'b1, exp});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic expect_err(input logic [2:0] code, input string req);
        wait_evt();
        chk(stopped && !out_valid && err_code == code, req,
            {58'd0, stopped, out_valid, 1'b0, err_code}, {58'd0, 1'b1, 1'b0, 1'b0, code});
        @(negedge clk);
        chk(stopped && !fetch_valid, "R10 idle", {62'd0, stopped, fetch_valid}, {62'd0, 2'b10});
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk(fetch_valid && fetch_addr == pc_w && err_code == 3'd0, "R10 resume R2",
            {fetch_valid, err_code, fetch_addr}, {1'b1, 3'd0, pc_w});
    endtask

    initial begin
        forever begin
            @(negedge clk);
            rc++;
            fetch_ready = (rc % 4) != 3;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R10 act=timeout exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pc0;
        rst_n = 1'b0; restart = 1'b0; out_ready = 1'b0; fetch_ready = 1'b1;
        end_addr = END_VAL;
        for (int i = 0; i < 256; i++) begin
            tbl_one[i]     = ok_one(i);
            tbl_esc[i]     = ok_esc(i);
            tbl_pf2[i]     = ok_pf2(i);
            tbl_pf3[i]     = ok_pf3(i);
            tbl_pf2_esc[i] = ok_pf2_esc(i);
            tbl_pf3_esc[i] = ok_pf3_esc(i);
        end
        for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(fetch_addr == 32'd1 && !out_valid && !stopped && err_code == 3'd0, "R1",
            {fetch_addr, 1'b0, out_valid, stopped, err_code}, {32'd1, 6'd0});

        // R3 halt at the first byte
        pc_w = 32'd1;
        put(8'hF4);
        rst_n = 1'b1;
        expect_rec(32'd1, 8'hF4, 8'h00, 8'h00, 3'd6, "R3 R9 halt record");
        chk(stopped && err_code == 3'd0 && !fetch_valid, "R3 stop",
            {60'd0, stopped, err_code}, {60'd0, 1'b1, 3'd0});
        repeat (3) @(negedge clk);
        chk(stopped && !fetch_valid, "R10 idle after halt", {62'd0, stopped, fetch_valid}, {62'd0, 2'b10});
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk(fetch_valid && fetch_addr == END_VAL, "R3 redirect", {32'd0, fetch_addr}, {32'd0, END_VAL});
        pc_w = END_VAL;

        // R7 R8 first-byte sweep
        for (int b = 0; b < 256; b++) begin
            if (b == 8'h0F || b == 8'hF2 || b == 8'hF3 || b == 8'hF4) continue;
            pc0 = pc_w;
            put(8'(b));
            if (ok_one(b)) expect_rec(pc0, 8'(b), 8'h00, 8'h00, 3'd0, "R7 R9 one-byte");
            else           expect_err(3'd1, "R8 first-level");
        end

        // R4 second byte after 0x0F
        for (int b = 0; b < 256; b++) begin
            pc0 = pc_w;
            put(8'h0F); put(8'(b));
            if (ok_esc(b)) expect_rec(pc0, 8'h0F, 8'(b), 8'h00, 3'd1, "R4 R9 escape pair");
            else           expect_err(3'd2, "R8 after-escape");
        end

        // R5 second byte after each prefix
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 256; b++) begin
                bit ok;
                if (b == 8'h0F) continue;
                ok  = (p == 0) ? ok_pf2(b) : ok_pf3(b);
                pc0 = pc_w;
                put(p == 0 ? 8'hF2 : 8'hF3); put(8'(b));
                if (ok) expect_rec(pc0, (p == 0 ? 8'hF2 : 8'hF3), 8'(b), 8'h00, 3'(2 + p), "R5 R9 prefixed");
                else    expect_err(3'd3, "R8 after-prefix");
            end
        end

        // R6 third byte after prefix and escape
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 256; b++) begin
                bit ok;
                ok  = (p == 0) ? ok_pf2_esc(b) : ok_pf3_esc(b);
                pc0 = pc_w;
                put(p == 0 ? 8'hF2 : 8'hF3); put(8'h0F); put(8'(b));
                if (ok) expect_rec(pc0, (p == 0 ? 8'hF2 : 8'hF3), 8'h0F, 8'(b), 3'(4 + p), "R6 R9 three-byte");
                else    expect_err(3'd4, "R8 third-level");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule